// File: doc/BRIEF.md
# Serial ADC Host Frame Controller

This block is the host-side serial master for a 14-bit converter whose only link to the host is a serial data output. It drives the chip-select and serial-clock lines and samples the data line on the host's own clock. Every exchange with the converter is a frame. A frame starts when chip select falls and ends when it rises. Its length is a fixed number of serial clocks, and that length sets which kind of frame it is.

After reset, and with no request from the host logic, the controller sends a 24-clock frame. This puts the converter into its offset-calibration state. After that, a pulse on the read request sends a 24-clock conversion frame, and the 14-bit sample comes back with a one-cycle strobe. A pulse on the calibrate request sends a 64-clock calibration frame. A request that arrives while a frame is running is held and served once chip select has been high for the minimum acquisition time. The busy flag covers the whole span from a request to the end of its frame.

The serial clock is the system clock divided by a parameter. The clock idles high, and the data line is sampled on each rising edge, most significant bit first.

Top module: `adc_serial_host`

## Requirements
- R1: While reset is held and in the first cycle after it, chip select and the serial clock are high, the result strobe is low and busy is high.
- R2: The first frame after reset starts without any request and has exactly 24 serial clocks. It produces no result strobe.
- R3: The serial clock is high whenever chip select is high. Inside a frame each serial clock period is a falling edge followed by a rising edge, and the data line is sampled at each rising edge.
- R4: A read frame has exactly 24 serial clocks. If received bits are numbered 1 to 24 in order, the result is bits 2 to 15, with bit 2 as the most significant. Bit 1 and bits 16 to 24 have no effect on the result. The result strobe is high for exactly one cycle, in the cycle in which chip select returns high, and the result bus holds its value until the next read frame ends.
- R5: A calibrate request produces a frame of exactly 64 serial clocks. That frame gives no result strobe and leaves the result bus unchanged.
- R6: A request that arrives during a frame is held and served by a later frame.
- R7: When a calibrate request and a read request are both waiting, the calibration frame is sent first and the read frame after it.
- R8: Chip select stays high for at least ACQ_CYCLES system clocks before any frame, including the first frame after reset.
- R9: Inside a frame the serial clock stays low for floor(CLK_DIV/2) system clocks and high for CLK_DIV minus that, and this includes the high phase before the first falling edge and the high phase after the last rising edge.
- R10: Busy is high from the cycle after a request until the cycle in which chip select returns high at the end of the frame that serves it. After that it is low when no request is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| read_req_i | input | 1 | Single-cycle request for a conversion read frame |
| cal_req_i | input | 1 | Single-cycle request for a run-time calibration frame |
| busy_o | output | 1 | A request is waiting or a frame is in progress |
| sample_o | output | SAMPLE_W | Result of the last read frame |
| sample_valid_o | output | 1 | One-cycle strobe when sample_o is updated |
| cs_n_o | output | 1 | Converter chip select, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| adc_dout_i | input | 1 | Serial data from the converter |

## Verification
The bench's converter model puts a one on the data line in the leading position and ones in all trailing positions. A controller that took the wrong 14-bit window, or did not mask the trailing bits, would return a corrupted sample. The bench sends a calibrate request in the middle of a read frame, and it also raises both requests in the same cycle. A controller that dropped a request, or served read before calibrate, would give frames of the wrong length or in the wrong order. The bench measures the phase lengths of the serial clock with an odd divider. An equal-halves divider would shorten or lengthen one phase, and a chip-select gap cut short would break the acquisition limit. The bench also checks that calibration frames raise no strobe and leave the result untouched.

// File: rtl/adc_serial_host_pkg.sv
// Shared types for the serial ADC host controller.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package adc_serial_host_pkg;

    // Frame kind; ordering has no behavioural meaning, priority is in the queue
    typedef enum logic [1:0] {
        FRM_PWRUP = 2'd0,
        FRM_CAL   = 2'd1,
        FRM_READ  = 2'd2
    } frame_kind_e;

    // Frame engine state
    typedef enum logic {
        ENG_IDLE  = 1'b0,
        ENG_SHIFT = 1'b1
    } eng_state_e;

endpackage

// File: rtl/ash_req_queue.sv
// Holds pending frame requests and picks the next one to serve.
// The power-up calibration is pending out of reset. Priority order is
// power-up, then run-time calibration, then read.
// Assumes take_i is only raised while pending_o is high.
module ash_req_queue
    import adc_serial_host_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        read_req_i,
    input  logic        cal_req_i,
    input  logic        take_i,
    output logic        pending_o,
    output frame_kind_e kind_o
);

    logic pwr_q, cal_q, rd_q;

    // Select the highest-priority pending kind
    always_comb begin
        if (pwr_q)      kind_o = FRM_PWRUP;
        else if (cal_q) kind_o = FRM_CAL;
        else            kind_o = FRM_READ;
    end

    assign pending_o = pwr_q | cal_q | rd_q;

    // Latch requests; a new request wins over a simultaneous take
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_q <= 1'b1;
            cal_q <= 1'b0;
            rd_q  <= 1'b0;
        end else begin
            pwr_q <= pwr_q & ~(take_i && kind_o == FRM_PWRUP);
            cal_q <= cal_req_i | (cal_q & ~(take_i && kind_o == FRM_CAL));
            rd_q  <= read_req_i | (rd_q & ~(take_i && kind_o == FRM_READ));
        end
    end

    // R6
    take_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> pending_o);

    // R7
    cal_before_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && $past(cal_req_i) && $past(read_req_i) && !pwr_q) |-> kind_o == FRM_CAL);

endmodule

// File: rtl/ash_frame_engine.sv
// Generates chip select and the serial clock for one frame at a time.
// It enforces the chip-select-high acquisition gap and counts serial clocks
// against the length set by the frame kind. The serial clock idles high.
// Each period starts with a high phase and ends with a low phase, and the
// frame closes with a trailing high phase.
// Assumes CLK_DIV >= 2 and ACQ_CYCLES >= 1.
module ash_frame_engine
    import adc_serial_host_pkg::*;
#(
    parameter int CLK_DIV    = 4,
    parameter int ACQ_CYCLES = 8,
    parameter int PWRUP_CLKS = 24,
    parameter int CAL_CLKS   = 64,
    parameter int READ_CLKS  = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pending_i,
    input  frame_kind_e kind_i,
    output logic        take_o,
    output logic        cs_n_o,
    output logic        sclk_o,
    output logic        rise_o,
    output logic        done_o,
    output frame_kind_e kind_o
);

    localparam int LO_CYC   = CLK_DIV / 2;
    localparam int HI_CYC   = CLK_DIV - LO_CYC;
    localparam int MAX_A    = (PWRUP_CLKS > CAL_CLKS) ? PWRUP_CLKS : CAL_CLKS;
    localparam int MAX_CLKS = (MAX_A > READ_CLKS) ? MAX_A : READ_CLKS;
    localparam int DIV_W    = $clog2(CLK_DIV);
    localparam int EDGE_W   = $clog2(MAX_CLKS + 1);
    localparam int GAP_W    = $clog2(ACQ_CYCLES + 1);

    eng_state_e        state_q, state_n;
    logic [DIV_W-1:0]  div_q, div_n;
    logic [EDGE_W-1:0] edge_q, edge_n, target;
    logic [GAP_W-1:0]  gap_q, gap_n;
    frame_kind_e       kind_q, kind_n;
    logic              cs_n_q, sclk_q;
    logic              last_phase, end_now;

    // Serial clock count for the frame in progress
    always_comb begin
        case (kind_q)
            FRM_PWRUP: target = EDGE_W'(PWRUP_CLKS);
            FRM_CAL:   target = EDGE_W'(CAL_CLKS);
            default:   target = EDGE_W'(READ_CLKS);
        endcase
    end

    assign last_phase = (div_q == DIV_W'(CLK_DIV - 1));
    assign end_now    = (state_q == ENG_SHIFT) && (edge_q == target) &&
                        (div_q == DIV_W'(HI_CYC - 1));
    assign take_o     = (state_q == ENG_IDLE) && pending_i &&
                        (gap_q == GAP_W'(ACQ_CYCLES));
    assign rise_o     = (state_q == ENG_SHIFT) && last_phase;
    assign done_o     = end_now;
    assign kind_o     = kind_q;
    assign cs_n_o     = cs_n_q;
    assign sclk_o     = sclk_q;

    // Next-state and counter logic for the gap and the frame
    always_comb begin
        state_n = state_q;
        div_n   = div_q;
        edge_n  = edge_q;
        gap_n   = gap_q;
        kind_n  = kind_q;
        case (state_q)
            ENG_IDLE: begin
                if (gap_q != GAP_W'(ACQ_CYCLES)) gap_n = gap_q + 1'b1;
                if (take_o) begin
                    state_n = ENG_SHIFT;
                    div_n   = '0;
                    edge_n  = '0;
                    kind_n  = kind_i;
                end
            end
            default: begin
                if (end_now) begin
                    state_n = ENG_IDLE;
                    gap_n   = '0;
                end else if (last_phase) begin
                    div_n  = '0;
                    edge_n = edge_q + 1'b1;
                end else begin
                    div_n = div_q + 1'b1;
                end
            end
        endcase
    end

    // State registers and registered pin drivers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENG_IDLE;
            div_q   <= '0;
            edge_q  <= '0;
            gap_q   <= '0;
            kind_q  <= FRM_PWRUP;
            cs_n_q  <= 1'b1;
            sclk_q  <= 1'b1;
        end else begin
            state_q <= state_n;
            div_q   <= div_n;
            edge_q  <= edge_n;
            gap_q   <= gap_n;
            kind_q  <= kind_n;
            cs_n_q  <= (state_n != ENG_SHIFT);
            sclk_q  <= !((state_n == ENG_SHIFT) && (div_n >= DIV_W'(HI_CYC)));
        end
    end

    // R3
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> sclk_o);

    // R3
    rise_inframe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> (!cs_n_o && !sclk_o));

    // R9
    sclk_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_o) |-> !cs_n_o);

endmodule

// File: rtl/ash_capture.sv
// Captures the sample from the serial data line during a frame.
// The first sampled bit is dropped, the next SAMPLE_W bits are shifted in
// MSB first, and any bits after them are ignored. The result is published
// with a one-cycle strobe when load_i marks the end of a read frame.
// Assumes READ_CLKS >= SAMPLE_W + 1 and that rise_i only occurs while active_i.
module ash_capture #(
    parameter int READ_CLKS = 24,
    parameter int SAMPLE_W  = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                active_i,
    input  logic                rise_i,
    input  logic                dout_i,
    input  logic                load_i,
    output logic [SAMPLE_W-1:0] sample_o,
    output logic                valid_o
);

    localparam int IDX_W = $clog2(SAMPLE_W + 2);
    localparam int STOP  = SAMPLE_W + 1;

    logic [IDX_W-1:0]    idx_q;
    logic [SAMPLE_W-1:0] shreg_q;
    logic [SAMPLE_W-1:0] sample_q;
    logic                valid_q;
    logic                in_window;

    assign in_window = (idx_q != '0) && (idx_q != IDX_W'(STOP));

    // Count sampled bits in the frame, saturating past the sample window
    always_ff @(posedge clk) begin
        if (!rst_n || !active_i)                   idx_q <= '0;
        else if (rise_i && idx_q != IDX_W'(STOP))  idx_q <= idx_q + 1'b1;
    end

    // Shift in only the bits inside the sample window
    always_ff @(posedge clk) begin
        if (!rst_n)                  shreg_q <= '0;
        else if (rise_i && in_window) shreg_q <= {shreg_q[SAMPLE_W-2:0], dout_i};
    end

    // Publish the result at the end of a read frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_q <= '0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= load_i;
            if (load_i) sample_q <= shreg_q;
        end
    end

    assign sample_o = sample_q;
    assign valid_o  = valid_q;

    // R4
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R4
    sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sample_o) |-> valid_o);

endmodule

// File: rtl/adc_serial_host.sv
// Top level of the serial ADC host controller: a request queue, a frame
// engine that drives chip select and the serial clock, and a capture unit.
// Busy covers waiting requests and the frame in progress.
// Assumes requests are single-cycle pulses synchronous to clk.
module adc_serial_host
    import adc_serial_host_pkg::*;
#(
    parameter int CLK_DIV    = 4,
    parameter int ACQ_CYCLES = 8,
    parameter int PWRUP_CLKS = 24,
    parameter int CAL_CLKS   = 64,
    parameter int READ_CLKS  = 24,
    parameter int SAMPLE_W   = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                read_req_i,
    input  logic                cal_req_i,
    output logic                busy_o,
    output logic [SAMPLE_W-1:0] sample_o,
    output logic                sample_valid_o,
    output logic                cs_n_o,
    output logic                sclk_o,
    input  logic                adc_dout_i
);

    localparam int MAX_A    = (PWRUP_CLKS > CAL_CLKS) ? PWRUP_CLKS : CAL_CLKS;
    localparam int MAX_CLKS = (MAX_A > READ_CLKS) ? MAX_A : READ_CLKS;
    localparam int EDGE_W   = $clog2(MAX_CLKS + 1);
    localparam int GAP_W    = $clog2(ACQ_CYCLES + 1);

    logic        pending, take, rise, done;
    frame_kind_e next_kind, cur_kind;

    ash_req_queue u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .read_req_i (read_req_i),
        .cal_req_i  (cal_req_i),
        .take_i     (take),
        .pending_o  (pending),
        .kind_o     (next_kind)
    );

    ash_frame_engine #(
        .CLK_DIV    (CLK_DIV),
        .ACQ_CYCLES (ACQ_CYCLES),
        .PWRUP_CLKS (PWRUP_CLKS),
        .CAL_CLKS   (CAL_CLKS),
        .READ_CLKS  (READ_CLKS)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending_i (pending),
        .kind_i    (next_kind),
        .take_o    (take),
        .cs_n_o    (cs_n_o),
        .sclk_o    (sclk_o),
        .rise_o    (rise),
        .done_o    (done),
        .kind_o    (cur_kind)
    );

    ash_capture #(
        .READ_CLKS (READ_CLKS),
        .SAMPLE_W  (SAMPLE_W)
    ) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (!cs_n_o),
        .rise_i   (rise),
        .dout_i   (adc_dout_i),
        .load_i   (done && cur_kind == FRM_READ),
        .sample_o (sample_o),
        .valid_o  (sample_valid_o)
    );

    assign busy_o = pending | !cs_n_o;

    // Checker state: chip-select-high run length and serial clock rises per frame
    logic [GAP_W-1:0]  acq_run;
    logic [EDGE_W-1:0] rise_run;
    logic              sclk_d, first_seen;

    // Track the gap and rising edges as observed on the pins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acq_run    <= '0;
            rise_run   <= '0;
            sclk_d     <= 1'b1;
            first_seen <= 1'b0;
        end else begin
            sclk_d <= sclk_o;
            if (cs_n_o && acq_run != GAP_W'(ACQ_CYCLES)) acq_run <= acq_run + 1'b1;
            else if (!cs_n_o)                            acq_run <= '0;
            if (cs_n_o)                   rise_run <= '0;
            else if (sclk_o && !sclk_d)   rise_run <= rise_run + 1'b1;
            if ($rose(cs_n_o))            first_seen <= 1'b1;
        end
    end

    // R8
    acq_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> acq_run == GAP_W'(ACQ_CYCLES));

    // R2
    first_frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cs_n_o) && !first_seen) |-> rise_run == EDGE_W'(PWRUP_CLKS));

    // R5
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> (rise_run == EDGE_W'(PWRUP_CLKS) ||
                           rise_run == EDGE_W'(CAL_CLKS) ||
                           rise_run == EDGE_W'(READ_CLKS)));

    // R4
    valid_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid_o |-> (cs_n_o && $rose(cs_n_o)));

    // R10
    busy_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_o |-> busy_o);

endmodule

// File: tb/adc_serial_host_bench.sv
// Directed bench for adc_serial_host with a behavioural converter model.
module adc_serial_host_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 5;
    localparam int ACQ        = 6;
    localparam int SW         = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          read_req = 1'b0;
    logic          cal_req = 1'b0;
    logic          busy;
    logic [SW-1:0] sample;
    logic          valid;
    logic          cs_n;
    logic          sclk;
    logic          dout = 1'b0;

    int checks = 0;
    int errors = 0;

    adc_serial_host #(
        .CLK_DIV    (DIV),
        .ACQ_CYCLES (ACQ)
    ) u_adc_serial_host (
        .clk            (clk),
        .rst_n          (rst_n),
        .read_req_i     (read_req),
        .cal_req_i      (cal_req),
        .busy_o         (busy),
        .sample_o       (sample),
        .sample_valid_o (valid),
        .cs_n_o         (cs_n),
        .sclk_o         (sclk),
        .adc_dout_i     (dout)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Converter model state
    logic [SW-1:0] model_sample = '0;
    logic          lead_val = 1'b0;
    logic          tail_val = 1'b0;
    int            rises = 0;
    int            frame_len [0:31];
    int            frames_done = 0;

    // Leading bit on chip-select fall
    always @(negedge cs_n) begin
        rises = 0;
        dout  = lead_val;
    end

    // Next bit launched after each rising edge
    always @(posedge sclk) begin
        if (cs_n === 1'b0) begin
            rises = rises + 1;
            #1;
            if (rises <= SW) dout = model_sample[SW - rises];
            else             dout = tail_val;
        end
    end

    // Record frame length when chip select returns high
    always @(posedge cs_n) begin
        if (rst_n && frames_done < 32) begin
            frame_len[frames_done] = rises;
            frames_done = frames_done + 1;
        end
    end

    // Pin monitor: phase lengths, gaps, idle level, strobes
    int gap_run = 0, gap_min = 1000;
    int run = 0, hi_min = 1000, hi_max = 0, lo_min = 1000, lo_max = 0;
    int idle_bad = 0, valid_cnt = 0;
    logic prev_cs = 1'b1, prev_sclk = 1'b1;
    logic [SW-1:0] last_valid = '0;

    task automatic record_run(input logic lvl, input int len);
        if (lvl) begin
            if (len < hi_min) hi_min = len;
            if (len > hi_max) hi_max = len;
        end else begin
            if (len < lo_min) lo_min = len;
            if (len > lo_max) lo_max = len;
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (cs_n) begin
                if (!prev_cs && run > 0) record_run(prev_sclk, run);
                gap_run = gap_run + 1;
                if (!sclk) idle_bad = idle_bad + 1;
                run = 0;
            end else begin
                if (prev_cs) begin
                    if (gap_run < gap_min) gap_min = gap_run;
                    gap_run = 0;
                    run = 1;
                end else if (sclk == prev_sclk) begin
                    run = run + 1;
                end else begin
                    record_run(prev_sclk, run);
                    run = 1;
                end
            end
            if (valid) begin
                valid_cnt  = valid_cnt + 1;
                last_valid = sample;
            end
            prev_cs   = cs_n;
            prev_sclk = sclk;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
        #1;
    endtask

    task automatic wait_frames(input int target);
        while (frames_done < target) tick();
    endtask

    task automatic settle;
        repeat (ACQ + 4) tick();
    endtask

    task automatic pulse(input bit rd, input bit cl);
        @(negedge clk);
        read_req = rd;
        cal_req  = cl;
        @(negedge clk);
        read_req = 1'b0;
        cal_req  = 1'b0;
        #1;
        check(busy === 1'b1, "R10 busy after request", int'(busy), 1);
    endtask

    // R1: state during and right after reset
    task automatic t_reset;
        rst_n = 1'b0;
        repeat (4) tick();
        check(cs_n === 1'b1, "R1 cs_n in reset", int'(cs_n), 1);
        check(sclk === 1'b1, "R1 sclk in reset", int'(sclk), 1);
        check(valid === 1'b0, "R1 valid in reset", int'(valid), 0);
        check(busy === 1'b1, "R1 busy in reset", int'(busy), 1);
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        check(cs_n === 1'b1 && sclk === 1'b1, "R1 pins after reset", int'({cs_n, sclk}), 3);
    endtask

    // R2: automatic power-up calibration frame
    task automatic t_powerup;
        wait_frames(1);
        tick();
        check(frame_len[0] == 24, "R2 power-up frame clocks", frame_len[0], 24);
        check(valid_cnt == 0, "R2 no strobe on power-up frame", valid_cnt, 0);
        check(gap_min >= ACQ, "R8 gap before first frame", gap_min, ACQ);
        check(busy === 1'b0, "R10 busy clear when idle", int'(busy), 0);
    endtask

    // R4: read frame with chosen data and filler bits
    task automatic t_read(input logic [SW-1:0] val, input logic lead, input logic tail);
        int n, v0;
        settle();
        model_sample = val;
        lead_val     = lead;
        tail_val     = tail;
        n  = frames_done;
        v0 = valid_cnt;
        pulse(1'b1, 1'b0);
        wait_frames(n + 1);
        tick();
        check(frame_len[n] == 24, "R4 read frame clocks", frame_len[n], 24);
        check(valid_cnt == v0 + 1, "R4 single strobe", valid_cnt - v0, 1);
        check(last_valid == val, "R4 sample at strobe", int'(last_valid), int'(val));
        check(sample == val, "R4 sample held", int'(sample), int'(val));
        check(busy === 1'b0, "R10 busy clear after read", int'(busy), 0);
        lead_val = 1'b0;
        tail_val = 1'b0;
    endtask

    // R5: run-time calibration frame
    task automatic t_cal;
        int n, v0;
        logic [SW-1:0] held;
        settle();
        held = sample;
        model_sample = ~held;
        n  = frames_done;
        v0 = valid_cnt;
        pulse(1'b0, 1'b1);
        wait_frames(n + 1);
        tick();
        check(frame_len[n] == 64, "R5 calibration frame clocks", frame_len[n], 64);
        check(valid_cnt == v0, "R5 no strobe on calibration", valid_cnt - v0, 0);
        check(sample == held, "R5 sample unchanged", int'(sample), int'(held));
    endtask

    // R6: calibrate request arriving during a read frame
    task automatic t_cal_during_read;
        int n;
        settle();
        model_sample = 14'h0ABC;
        n = frames_done;
        pulse(1'b1, 1'b0);
        while (cs_n) tick();
        repeat (10) tick();
        pulse(1'b0, 1'b1);
        wait_frames(n + 2);
        tick();
        check(frame_len[n] == 24, "R6 first frame is read", frame_len[n], 24);
        check(frame_len[n + 1] == 64, "R6 held calibration served", frame_len[n + 1], 64);
        check(last_valid == 14'h0ABC, "R6 read result intact", int'(last_valid), 'h0ABC);
        check(gap_min >= ACQ, "R8 gap between back-to-back frames", gap_min, ACQ);
    endtask

    // R7: both requests waiting together
    task automatic t_priority;
        int n;
        settle();
        model_sample = 14'h155A;
        n = frames_done;
        pulse(1'b1, 1'b1);
        wait_frames(n + 2);
        tick();
        check(frame_len[n] == 64, "R7 calibration first", frame_len[n], 64);
        check(frame_len[n + 1] == 24, "R7 read second", frame_len[n + 1], 24);
        check(sample == 14'h155A, "R7 read result", int'(sample), 'h155A);
    endtask

    // R3, R9: serial clock shape
    task automatic t_timing;
        check(idle_bad == 0, "R3 sclk high while deselected", idle_bad, 0);
        check(hi_min == DIV - DIV / 2 && hi_max == DIV - DIV / 2, "R9 high phase",
              hi_max * 100 + hi_min, (DIV - DIV / 2) * 101);
        check(lo_min == DIV / 2 && lo_max == DIV / 2, "R9 low phase",
              lo_max * 100 + lo_min, (DIV / 2) * 101);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors = errors + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_powerup();
        t_read(14'h1A5C, 1'b0, 1'b0);
        t_read(14'h3FFF, 1'b0, 1'b0);
        t_read(14'h0001, 1'b1, 1'b1);
        t_read(14'h2000, 1'b0, 1'b1);
        t_cal();
        t_cal_during_read();
        t_priority();
        t_timing();
        finish_run();
    end

endmodule